// File: doc/BRIEF.md
# Register and Memory Command Engine

This block sits behind a bus node and turns each received message into local work. A 4-bit function code picks one of four operations. Register writes update a small internal register file. Register reads send the requested registers back as a new message. Block writes put data words at consecutive memory addresses. Stream writes append words to a circular buffer region of the same memory port. The function code normally comes from the low nibble of the message address. A node that has no address bits to offer sends the code in the top nibble of a leading header word instead.

A read request names where its answer goes. The reply leaves as an ordinary register-write message aimed at that address, repacked so that the receiver applies it without help. This lets one peripheral load another peripheral's registers with no processor in between. An unknown function code drops the message and raises a one-cycle NAK pulse toward the bus node. While a reply is being emitted, the block stops accepting input words.

Top module: `cmd_engine`

## Requirements
- R1: When `rx_addr_ok` is high on a message's first word, the function code is `rx_addr[3:0]` and the upper address bits have no effect. The codes are 0 register write, 1 register read, 2 block memory write and 3 stream append.
- R2: When `rx_addr_ok` is low on the first word, the code is `rx_data[31:28]` of that word. That word is a header only, and its other bits have no effect.
- R3: Each register-write payload word carries the index in bits [31:24] and the 24-bit value in bits [23:0]. Words are applied in arrival order, so a later word to the same index wins. Indices at or above `NREG` are ignored.
- R4: A register-read payload is two words. Word 0 holds the start index in [7:0], the count in [15:8] and the reply index in [23:16]. Word 1 holds the reply address. Starting the cycle after the last request word, the block emits `count` words on consecutive cycles. All of them carry `tx_addr` equal to the reply address. `tx_first` marks the first word and `tx_last` marks the last. Word i is {reply index + i, register[start + i]}, with both indices wrapping at 8 bits, and registers out of range read as 0. A count of 0, or a request shorter than two payload words, produces no reply.
- R5: `rx_ready` is low exactly while reply words are being emitted, and high at all other times.
- R6: In a block write, payload word 0 gives the start address (its low `MEM_AW` bits). Each later word is written to the next consecutive address, and `mem_we` pulses in the cycle after that word is accepted.
- R7: Each stream word is written at `STREAM_BASE` plus an internal pointer. The pointer steps by one, wraps to 0 after `STREAM_LEN`-1 and keeps its value across messages. `stream_alert` pulses together with the write into the last slot.
- R8: An unknown function code (4 to 15) gives a one-cycle `nak` pulse in the cycle after the first word. The rest of that message writes no memory, changes no register and produces no reply.
- R9: After reset `rx_ready` is 1, `tx_valid`, `mem_we`, `nak` and `stream_alert` are 0, every register reads 0 and the stream pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received word present |
| rx_ready | output | 1 | Block accepts a received word this cycle |
| rx_first | input | 1 | Word is the first of a message |
| rx_last | input | 1 | Word is the last of a message |
| rx_addr_ok | input | 1 | Message address carries the function code |
| rx_addr | input | 32 | Message destination address, valid with rx_first |
| rx_data | input | 32 | Received data word |
| tx_valid | output | 1 | Reply word present |
| tx_first | output | 1 | First reply word |
| tx_last | output | 1 | Last reply word |
| tx_addr | output | 32 | Reply destination address |
| tx_data | output | 32 | Reply word {index, value} |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| nak | output | 1 | Unsupported-function pulse |
| stream_alert | output | 1 | Stream buffer filled its last slot |

## Verification
A table of write-then-read pairs runs the register path with in-range, top-of-range, out-of-range and repeated indices. It also uses an address whose upper bits are noise, which separates correct nibble decoding and index filtering from sloppy ones. Multi-word writes with a repeated index, followed by a two-register read, show whether arrival order and reply framing (first/last flags, index stepping, wrap of the reply index) are right. A header-mode message whose header word would look like a valid write shows whether the header is mistaken for payload. Block and stream writes that cross a message boundary and wrap the buffer separate address stepping, pointer persistence and alert timing. Unknown codes in both addressing modes confirm that nothing downstream moves.

// File: rtl/cmd_pkg.sv
package cmd_pkg;

  localparam int WORD_W = 32;
  localparam int IDX_W  = 8;
  localparam int VAL_W  = 24;

  localparam logic [3:0] FN_REG_WRITE = 4'h0;
  localparam logic [3:0] FN_REG_READ  = 4'h1;
  localparam logic [3:0] FN_MEM_BLOCK = 4'h2;
  localparam logic [3:0] FN_STREAM    = 4'h3;

  typedef struct packed {
    logic [IDX_W-1:0] reply_idx;
    logic [IDX_W-1:0] count;
    logic [IDX_W-1:0] start;
  } rd_hdr_t;

  function automatic logic [3:0] pick_fn(input logic addr_ok,
                                         input logic [3:0] addr_lo,
                                         input logic [3:0] data_hi);
    return addr_ok ? addr_lo : data_hi;
  endfunction

  function automatic logic fn_known(input logic [3:0] fn);
    return fn <= FN_STREAM;
  endfunction

  function automatic logic [WORD_W-1:0] pack_reg_word(input logic [IDX_W-1:0] idx,
                                                      input logic [VAL_W-1:0] val);
    return {idx, val};
  endfunction

  function automatic rd_hdr_t unpack_rd_hdr(input logic [WORD_W-1:0] w);
    return rd_hdr_t'(w[3*IDX_W-1:0]);
  endfunction

endpackage

// File: rtl/cmd_fn_decode.sv
module cmd_fn_decode
  import cmd_pkg::*;
(
  input  logic       addr_ok,
  input  logic [3:0] addr_lo,
  input  logic [3:0] data_hi,
  output logic [3:0] fn,
  output logic       hdr_only,
  output logic       known
);

  always_comb begin
    fn       = pick_fn(addr_ok, addr_lo, data_hi);
    hdr_only = !addr_ok;
    known    = fn_known(fn);
  end

endmodule

// File: rtl/cmd_regfile.sv
module cmd_regfile
  import cmd_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [VAL_W-1:0] wval,
  input  logic [IDX_W-1:0] ridx,
  output logic [VAL_W-1:0] rval
);

  logic [VAL_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             regs[g] <= '0;
      else if (we && widx == IDX_W'(g))       regs[g] <= wval;
    end
  end

  always_comb begin
    rval = '0;
    for (int i = 0; i < NREG; i++) begin
      if (ridx == IDX_W'(i)) rval = regs[i];
    end
  end

endmodule

// File: rtl/cmd_memport.sv
module cmd_memport
  import cmd_pkg::*;
#(
  parameter int MEM_AW      = 16,
  parameter int STREAM_BASE = 'hF000,
  parameter int STREAM_LEN  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_we,
  input  logic [MEM_AW-1:0] blk_addr,
  input  logic              str_we,
  input  logic [WORD_W-1:0] wdata,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              alert
);

  localparam int PW = (STREAM_LEN > 1) ? $clog2(STREAM_LEN) : 1;
  localparam logic [PW-1:0] PTR_LAST = PW'(STREAM_LEN - 1);

  logic [PW-1:0] ptr_q;
  logic          ptr_at_last;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PW'(1);
  endfunction

  assign ptr_at_last = (ptr_q == PTR_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      alert     <= 1'b0;
    end else begin
      mem_we <= blk_we || str_we;
      alert  <= str_we && ptr_at_last;
      if (blk_we || str_we) mem_wdata <= wdata;
      if (blk_we)      mem_addr <= blk_addr;
      else if (str_we) mem_addr <= MEM_AW'(STREAM_BASE) + MEM_AW'(ptr_q);
      if (str_we) ptr_q <= ptr_next(ptr_q);
    end
  end

  assert_ptr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PTR_LAST);
  assert_alert_with_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alert |-> mem_we);
  assert_ptr_wraps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (str_we && ptr_at_last) |=> ptr_q == '0);
  assert_single_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(blk_we && str_we));

endmodule

// File: rtl/cmd_engine.sv
module cmd_engine
  import cmd_pkg::*;
#(
  parameter int NREG        = 16,
  parameter int MEM_AW      = 16,
  parameter int STREAM_BASE = 'hF000,
  parameter int STREAM_LEN  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              rx_first,
  input  logic              rx_last,
  input  logic              rx_addr_ok,
  input  logic [31:0]       rx_addr,
  input  logic [31:0]       rx_data,
  output logic              tx_valid,
  output logic              tx_first,
  output logic              tx_last,
  output logic [31:0]       tx_addr,
  output logic [31:0]       tx_data,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              nak,
  output logic              stream_alert
);

  typedef enum logic {ST_RECV, ST_REPLY} st_e;

  st_e              st_q;
  logic             in_msg_q;
  logic [3:0]       fn_q;
  logic [1:0]       k_q;
  rd_hdr_t          rd_q;
  logic [31:0]      dest_q;
  logic [MEM_AW-1:0] blk_ptr_q;
  logic [IDX_W-1:0] rep_i_q;
  logic             nak_q;

  logic [3:0]       dec_fn;
  logic             dec_hdr, dec_known;
  logic             acc, is_pay, pay;
  logic [3:0]       cur_fn;
  logic [1:0]       cur_k;
  logic             ev_regwr, ev_rd_hdr, ev_rd_dest, ev_blk_base, ev_blk_wr;
  logic             ev_str_wr, ev_nak, ev_reply_go, ev_reply_end;
  logic [VAL_W-1:0] rd_val;
  logic             unused_bits;

  assign unused_bits = ^{rx_addr[31:4], rx_data[31:24]};

  cmd_fn_decode u_dec (
    .addr_ok  (rx_addr_ok),
    .addr_lo  (rx_addr[3:0]),
    .data_hi  (rx_data[31:28]),
    .fn       (dec_fn),
    .hdr_only (dec_hdr),
    .known    (dec_known)
  );

  assign rx_ready = (st_q == ST_RECV);
  assign acc      = rx_valid && rx_ready;
  assign cur_fn   = rx_first ? dec_fn : fn_q;
  assign is_pay   = rx_first ? !dec_hdr : in_msg_q;
  assign cur_k    = rx_first ? 2'd0 : k_q;
  assign pay      = acc && is_pay;

  assign ev_regwr     = pay && cur_fn == FN_REG_WRITE;
  assign ev_rd_hdr    = pay && cur_fn == FN_REG_READ && cur_k == 2'd0;
  assign ev_rd_dest   = pay && cur_fn == FN_REG_READ && cur_k == 2'd1;
  assign ev_blk_base  = pay && cur_fn == FN_MEM_BLOCK && cur_k == 2'd0;
  assign ev_blk_wr    = pay && cur_fn == FN_MEM_BLOCK && cur_k != 2'd0;
  assign ev_str_wr    = pay && cur_fn == FN_STREAM;
  assign ev_nak       = acc && rx_first && !dec_known;
  assign ev_reply_go  = pay && rx_last && cur_fn == FN_REG_READ &&
                        cur_k != 2'd0 && rd_q.count != '0;
  assign ev_reply_end = (st_q == ST_REPLY) && tx_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_RECV;
      in_msg_q  <= 1'b0;
      fn_q      <= '0;
      k_q       <= '0;
      rd_q      <= '0;
      dest_q    <= '0;
      blk_ptr_q <= '0;
      rep_i_q   <= '0;
      nak_q     <= 1'b0;
    end else begin
      nak_q <= ev_nak;
      if (acc) begin
        if (rx_first) begin
          fn_q     <= dec_fn;
          in_msg_q <= !rx_last;
          k_q      <= dec_hdr ? 2'd0 : 2'd1;
        end else if (in_msg_q) begin
          if (rx_last)        in_msg_q <= 1'b0;
          if (k_q != 2'd2)    k_q <= k_q + 2'd1;
        end
      end
      if (ev_rd_hdr)   rd_q      <= unpack_rd_hdr(rx_data);
      if (ev_rd_dest)  dest_q    <= rx_data;
      if (ev_blk_base) blk_ptr_q <= rx_data[MEM_AW-1:0];
      if (ev_blk_wr)   blk_ptr_q <= blk_ptr_q + MEM_AW'(1);
      if (ev_reply_go) begin
        st_q    <= ST_REPLY;
        rep_i_q <= '0;
      end else if (ev_reply_end) begin
        st_q <= ST_RECV;
      end else if (st_q == ST_REPLY) begin
        rep_i_q <= rep_i_q + IDX_W'(1);
      end
    end
  end

  cmd_regfile #(.NREG(NREG)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ev_regwr),
    .widx  (rx_data[31:24]),
    .wval  (rx_data[23:0]),
    .ridx  (rd_q.start + rep_i_q),
    .rval  (rd_val)
  );

  cmd_memport #(
    .MEM_AW      (MEM_AW),
    .STREAM_BASE (STREAM_BASE),
    .STREAM_LEN  (STREAM_LEN)
  ) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_we    (ev_blk_wr),
    .blk_addr  (blk_ptr_q),
    .str_we    (ev_str_wr),
    .wdata     (rx_data),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .alert     (stream_alert)
  );

  assign tx_valid = (st_q == ST_REPLY);
  assign tx_first = tx_valid && rep_i_q == '0;
  assign tx_last  = tx_valid && rep_i_q == rd_q.count - IDX_W'(1);
  assign tx_addr  = dest_q;
  assign tx_data  = pack_reg_word(rd_q.reply_idx + rep_i_q, rd_val);
  assign nak      = nak_q;

  assert_reply_blocks_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rx_ready);
  assert_reply_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_last) |=> !tx_valid);
  assert_reply_starts_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> tx_first);
  assert_reply_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_first) |-> $stable(tx_addr));
  assert_nak_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nak |-> $past(rx_valid && rx_ready && rx_first));
  assert_nak_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nak && !$past(rx_valid && rx_ready && rx_first, 2)) |=> !nak || $past(acc && rx_first));
  assert_memwr_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(rx_valid && rx_ready));

endmodule

// File: tb/cmd_engine_tb.sv
module cmd_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int VEC_N = 6;
  // {write index, write value, expected read value}
  localparam logic [55:0] VEC [VEC_N] = '{
    {8'd3,   24'h123456, 24'h123456},
    {8'd15,  24'hABCDEF, 24'hABCDEF},
    {8'd0,   24'hFFFFFF, 24'hFFFFFF},
    {8'd16,  24'h111111, 24'h000000},
    {8'd200, 24'h222222, 24'h000000},
    {8'd3,   24'h000042, 24'h000042}
  };

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_first = 0, rx_last = 0, rx_addr_ok = 1;
  logic [31:0] rx_addr = '0, rx_data = '0;
  logic rx_ready, tx_valid, tx_first, tx_last, mem_we, nak, stream_alert;
  logic [31:0] tx_addr, tx_data, mem_wdata;
  logic [15:0] mem_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int tx_n, mem_n, nak_n, alert_n, busy_n, overlap_n;
  logic [31:0] tx_d [16];
  logic        tx_f [16];
  logic        tx_l [16];
  logic [31:0] tx_a;
  logic [15:0] mem_a [16];
  logic [31:0] mem_d [16];
  logic [15:0] alert_a;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_first(rx_first), .rx_last(rx_last), .rx_addr_ok(rx_addr_ok),
    .rx_addr(rx_addr), .rx_data(rx_data), .tx_valid(tx_valid),
    .tx_first(tx_first), .tx_last(tx_last), .tx_addr(tx_addr),
    .tx_data(tx_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .nak(nak), .stream_alert(stream_alert)
  );

  always @(negedge clk) if (rst_n) begin
    if (tx_valid) begin
      if (tx_n < 16) begin
        tx_d[tx_n] = tx_data; tx_f[tx_n] = tx_first; tx_l[tx_n] = tx_last;
      end
      tx_a = tx_addr;
      tx_n++;
    end
    if (tx_valid && rx_ready) overlap_n++;
    if (!rx_ready) busy_n++;
    if (mem_we) begin
      if (mem_n < 16) begin mem_a[mem_n] = mem_addr; mem_d[mem_n] = mem_wdata; end
      mem_n++;
    end
    if (nak) nak_n++;
    if (stream_alert) begin alert_n++; alert_a = mem_addr; end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr();
    @(posedge clk); #1;
    tx_n = 0; mem_n = 0; nak_n = 0; alert_n = 0; busy_n = 0; overlap_n = 0;
  endtask

  task automatic send(input bit f, input bit l, input bit aok, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    rx_valid = 1; rx_first = f; rx_last = l; rx_addr_ok = aok; rx_addr = a; rx_data = d;
  endtask

  task automatic settle(input int n);
    @(negedge clk);
    rx_valid = 0; rx_first = 0; rx_last = 0; rx_addr_ok = 1;
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [23:0] val);
    send(1, 1, 1, 32'hDEAD_BEE0, {idx, val});
    settle(2);
  endtask

  task automatic rd_regs(input logic [7:0] start, input logic [7:0] cnt,
                         input logic [7:0] ridx, input logic [31:0] dest);
    clr();
    send(1, 0, 1, 32'h0000_0011, {8'h00, ridx, cnt, start});
    send(0, 1, 1, 32'h0, dest);
    settle(int'(cnt) + 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rx_ready === 1'b1, "R9 rx_ready in reset", 32'(rx_ready), 1);
    chk(tx_valid === 0 && mem_we === 0 && nak === 0 && stream_alert === 0,
        "R9 outputs idle in reset", {tx_valid, mem_we, nak, stream_alert}, 0);
    rst_n = 1;
    settle(2);
    rd_regs(8'd5, 8'd1, 8'h00, 32'hC000_0001);
    chk(tx_n == 1 && tx_d[0] == 32'h0500_0000 - 32'h0500_0000, "R9 register reads 0 after reset",
        tx_d[0], 32'h0);

    // Table walk: R1 (upper address bits are noise), R3 index filter, R4 single read
    for (int v = 0; v < VEC_N; v++) begin
      wr_reg(VEC[v][55:48], VEC[v][47:24]);
      rd_regs(VEC[v][55:48], 8'd1, 8'h55, 32'hA000_0010);
      chk(tx_n == 1 && tx_d[0] == {8'h55, VEC[v][23:0]}, "R1 R3 table readback",
          tx_d[0], {8'h55, VEC[v][23:0]});
      chk(tx_f[0] === 1 && tx_l[0] === 1 && tx_a == 32'hA000_0010, "R4 single-word framing",
          tx_a, 32'hA000_0010);
    end

    // R3 arrival order, R4 multi-word reply, R5 busy window
    send(1, 0, 1, 32'h0000_0000, {8'd1, 24'h000010});
    send(0, 0, 1, 32'h0, {8'd2, 24'h000020});
    send(0, 1, 1, 32'h0, {8'd1, 24'h000030});
    settle(2);
    rd_regs(8'd1, 8'd2, 8'h08, 32'hB000_0021);
    chk(tx_n == 2, "R4 reply word count", tx_n, 2);
    chk(tx_d[0] == 32'h0800_0030, "R3 later word wins", tx_d[0], 32'h0800_0030);
    chk(tx_d[1] == 32'h0900_0020, "R4 second reply word", tx_d[1], 32'h0900_0020);
    chk(tx_f[0] === 1 && tx_l[0] === 0 && tx_f[1] === 0 && tx_l[1] === 1,
        "R4 first/last flags", {tx_f[0], tx_l[0], tx_f[1], tx_l[1]}, 4'b1001);
    chk(busy_n == 2 && overlap_n == 0, "R5 rx_ready low only during reply", busy_n, 2);

    // R4 wrap of reply index and out-of-range source
    rd_regs(8'd15, 8'd2, 8'hFF, 32'hB000_0031);
    chk(tx_n == 2 && tx_d[0] == 32'hFFAB_CDEF, "R4 reply at top register", tx_d[0], 32'hFFAB_CDEF);
    chk(tx_d[1] == 32'h0000_0000, "R4 index wrap and out-of-range reads 0", tx_d[1], 0);

    // R4 count zero, and short request
    rd_regs(8'd3, 8'd0, 8'h00, 32'hB000_0041);
    chk(tx_n == 0 && busy_n == 0, "R4 count 0 sends nothing", tx_n, 0);
    clr();
    send(1, 1, 1, 32'h0000_0001, {8'h00, 8'h00, 8'd1, 8'd3});
    settle(5);
    chk(tx_n == 0, "R4 short request sends nothing", tx_n, 0);

    // R2 header mode: header word looks like a write to reg 10
    send(1, 0, 0, 32'hFFFF_FFFF, 32'h0ABC_DEF0);
    send(0, 1, 0, 32'h0, {8'd7, 24'h777777});
    settle(2);
    rd_regs(8'd7, 8'd4, 8'h00, 32'hC000_0001);
    chk(tx_n == 4 && tx_d[0] == 32'h0077_7777, "R2 payload after header", tx_d[0], 32'h0077_7777);
    chk(tx_d[3] == 32'h0300_0000, "R2 header bits not applied (reg 10)", tx_d[3], 32'h0300_0000);

    // R6 block write
    clr();
    send(1, 0, 1, 32'h0000_0002, 32'hFFFF_0100);
    send(0, 0, 1, 32'h0, 32'hD0D0_0000);
    send(0, 0, 1, 32'h0, 32'hD1D1_0001);
    send(0, 1, 1, 32'h0, 32'hD2D2_0002);
    settle(3);
    chk(mem_n == 3, "R6 block write count", mem_n, 3);
    for (int i = 0; i < 3; i++)
      chk(mem_a[i] == 16'h0100 + 16'(i) && mem_d[i] == 32'hD0D0_0000 + 32'h0101_0001 * i,
          "R6 block write address/data", {mem_a[i], mem_d[i][15:0]}, {16'h0100 + 16'(i), 16'(i)});
    chk(alert_n == 0 && nak_n == 0, "R6 no alert or nak", alert_n, 0);

    // R7 stream: 6 then 4 words, wraps, alert at last slot
    clr();
    for (int i = 0; i < 6; i++) send(i == 0, i == 5, 1, 32'h0000_0003, 32'h5000 + i);
    for (int i = 6; i < 10; i++) send(i == 6, i == 9, 1, 32'h0000_0003, 32'h5000 + i);
    settle(3);
    chk(mem_n == 10, "R7 stream write count", mem_n, 10);
    for (int i = 0; i < 10; i++)
      chk(mem_a[i] == 16'hF000 + 16'(i % 8) && mem_d[i] == 32'h5000 + i, "R7 stream address",
          mem_a[i], 16'hF000 + 16'(i % 8));
    chk(alert_n == 1 && alert_a == 16'hF007, "R7 alert at last slot", alert_a, 16'hF007);

    // R8 unknown codes, both addressing modes
    clr();
    send(1, 0, 1, 32'h0000_0005, {8'd3, 24'h999999});
    send(0, 1, 1, 32'h0, 32'h0000_0100);
    settle(2);
    send(1, 0, 0, 32'h0, 32'hF000_0000);
    send(0, 1, 0, 32'h0, {8'd3, 24'h888888});
    settle(3);
    chk(nak_n == 2, "R8 one nak cycle per bad message", nak_n, 2);
    chk(mem_n == 0 && tx_n == 0, "R8 no memory write or reply", mem_n, 0);
    rd_regs(8'd3, 8'd1, 8'h00, 32'hC000_0001);
    chk(tx_d[0] == 32'h0000_0042, "R8 register untouched", tx_d[0], 32'h0000_0042);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule